// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block lights a panel of five display positions one at a time: four seven-segment digits and a single centre dot. Each digit takes a 4-bit value, which is turned into a segment pattern, along with a blank flag and a decimal-point flag. The pattern leaves the block as an 8-bit serial word on a clock/data pair. It feeds an external serial-in, parallel-out shift register that has no output latch. Because that register's outputs follow every shift, all position enables are held off while a word is shifted and during a short settle time after it. Only then is the enable of the selected position driven low for a fixed dwell time.

The control is a four-state machine. In `SC_LOAD` (one cycle) the word for the current position is captured and the shift starts. The transition `SC_LOAD -> SC_SHIFT` is unconditional. `SC_SHIFT -> SC_SETTLE` is taken on the cycle the eighth clock pulse ends. `SC_SETTLE -> SC_DWELL` is taken when the settle count expires. `SC_DWELL -> SC_LOAD` is taken when the dwell count expires, and it also advances the position index, wrapping from 4 to 0. One position slot lasts `1 + 16*SCLK_HALF + SETTLE_CYCLES + DWELL_CYCLES` clock cycles.

Top module: `seg_scan`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, all enables are high, `spi_sclk` is low, `spi_mosi` is low and the scan starts at position 0.
- R2: Positions are lit in the order 0, 1, 2, 3, 4 and then wrap to 0. Position p owns `pos_en_n[p]` (positions 0 to 3 are the digits, position 4 is the dot).
- R3: At no time is more than one enable low.
- R4: All enables stay high from the start of a shift until the settle time has passed.
- R5: `spi_sclk` idles low. Each word has exactly 8 pulses, each `SCLK_HALF` cycles low followed by `SCLK_HALF` cycles high. Data changes only as the clock falls, so it is stable while the clock is high.
- R6: The word is sent most significant bit first: bit 7 is on `spi_mosi` for the first pulse and bit 0 for the last.
- R7: Segment word bits are active low. Bit 0 is segment a, through bit 6 for segment g, and bit 7 is the decimal point. Values 0 to F light the active-high gfedcba patterns 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71, so the word is the bitwise inverse of the pattern with the point bit included.
- R8: A digit whose blank flag is set sends 8'hFF, whatever its value and point flag.
- R9: A digit whose point flag is set, and which is not blanked, has bit 7 low.
- R10: Position 4 sends 8'h7F when `dot_on` is high and 8'hFF when it is low.
- R11: Settle lasts `SETTLE_CYCLES` and the enable stays low for exactly `DWELL_CYCLES` cycles, giving the slot length above.
- R12: Inputs are captured in the `SC_LOAD` cycle. Changes later in a slot do not alter that slot's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_val | input | 16 | Four 4-bit digit values, digit p in bits 4p+3:4p |
| digit_blank | input | 4 | Per-digit blank flag |
| digit_dp | input | 4 | Per-digit decimal-point flag |
| dot_on | input | 1 | Centre dot lit when high |
| spi_sclk | output | 1 | Shift clock to the external register |
| spi_mosi | output | 1 | Serial segment data |
| pos_en_n | output | 5 | Active-low position enables |

## Verification
In a slot starting with the load cycle at offset 0, bit b is on `spi_mosi` from offset 1+2b*SCLK_HALF. `spi_sclk` is high in the second half of each bit. Enables stay high until offset 16*SCLK_HALF+SETTLE_CYCLES, and the enable of the current position is low for the following `DWELL_CYCLES` cycles. The bench keeps a slot offset and position count of its own, captures the expected word from the inputs at offset 0, and compares clock, data and all enables at every falling clock edge. Input changes are placed both on slot boundaries and in the middle of slots, so that capture timing is exercised.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

    typedef enum logic [1:0] {
        SC_LOAD   = 2'd0,
        SC_SHIFT  = 2'd1,
        SC_SETTLE = 2'd2,
        SC_DWELL  = 2'd3
    } scan_state_e;

    localparam int SEG_W = 8;

endpackage

// File: rtl/seg_hex_decoder.sv
module seg_hex_decoder (
    input  logic [3:0] nibble,
    input  logic       blank,
    input  logic       dp,
    output logic [7:0] word_n
);
    logic [6:0] gfedcba;

    always_comb begin
        unique case (nibble)
            4'h0: gfedcba = 7'h3F;
            4'h1: gfedcba = 7'h06;
            4'h2: gfedcba = 7'h5B;
            4'h3: gfedcba = 7'h4F;
            4'h4: gfedcba = 7'h66;
            4'h5: gfedcba = 7'h6D;
            4'h6: gfedcba = 7'h7D;
            4'h7: gfedcba = 7'h07;
            4'h8: gfedcba = 7'h7F;
            4'h9: gfedcba = 7'h6F;
            4'hA: gfedcba = 7'h77;
            4'hB: gfedcba = 7'h7C;
            4'hC: gfedcba = 7'h39;
            4'hD: gfedcba = 7'h5E;
            4'hE: gfedcba = 7'h79;
            default: gfedcba = 7'h71;
        endcase
    end

    // Active-low outputs; blank overrides both segments and point (R8, R9)
    always_comb begin
        if (blank) word_n = 8'hFF;
        else       word_n = {~dp, ~gfedcba};
    end
endmodule

// File: rtl/seg_word_shifter.sv
module seg_word_shifter #(
    parameter int WORD_W = 8,
    parameter int HALF   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done
);
    localparam int PH_W  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic [WORD_W-1:0] sreg_q;
    logic [PH_W-1:0]   ph_q;
    logic [BIT_W-1:0]  bit_q;
    logic              sclk_q, busy_q;
    logic              ph_last, bit_last;

    assign ph_last  = (ph_q == PH_W'(HALF - 1));
    assign bit_last = (bit_q == BIT_W'(WORD_W - 1));
    assign done     = busy_q && ph_last && sclk_q && bit_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            ph_q   <= '0;
            bit_q  <= '0;
            sclk_q <= 1'b0;
            busy_q <= 1'b0;
        end else if (start && !busy_q) begin
            sreg_q <= word;
            ph_q   <= '0;
            bit_q  <= '0;
            sclk_q <= 1'b0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (ph_last) begin
                ph_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                end else begin
                    sclk_q <= 1'b0;
                    sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
                    if (bit_last) busy_q <= 1'b0;
                    else          bit_q  <= bit_q + 1'b1;
                end
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    assign sclk = sclk_q;
    assign mosi = sreg_q[WORD_W-1];
    assign busy = busy_q;

    p_sclk_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk_q);
    p_data_held_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && $past(sclk_q)) |-> $stable(mosi));
    p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy_q);
endmodule

// File: rtl/seg_dwell_timer.sv
module seg_dwell_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    p_count_down_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/seg_scan.sv
module seg_scan #(
    parameter int NUM_DIGITS    = 4,
    parameter int SCLK_HALF     = 2,
    parameter int SETTLE_CYCLES = 4,
    parameter int DWELL_CYCLES  = 64,
    parameter int TMR_W         = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [4*NUM_DIGITS-1:0] digit_val,
    input  logic [NUM_DIGITS-1:0]   digit_blank,
    input  logic [NUM_DIGITS-1:0]   digit_dp,
    input  logic                    dot_on,
    output logic                    spi_sclk,
    output logic                    spi_mosi,
    output logic [NUM_DIGITS:0]     pos_en_n
);
    import seg_scan_pkg::*;

    localparam int NUM_POS = NUM_DIGITS + 1;
    localparam int POS_W   = $clog2(NUM_POS);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_POS - 1);

    scan_state_e      state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;

    logic [SEG_W-1:0] digit_word [NUM_POS];
    logic [SEG_W-1:0] cur_word;
    logic             sh_start, sh_busy, sh_done;
    logic             tmr_load, tmr_expired;
    logic [TMR_W-1:0] tmr_val;

    // Per-digit decoders, dot position appended last
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dec
        seg_hex_decoder u_dec (
            .nibble (digit_val[4*g +: 4]),
            .blank  (digit_blank[g]),
            .dp     (digit_dp[g]),
            .word_n (digit_word[g])
        );
    end
    assign digit_word[NUM_DIGITS] = dot_on ? 8'h7F : 8'hFF;

    assign cur_word = digit_word[pos_q];

    seg_word_shifter #(.WORD_W(SEG_W), .HALF(SCLK_HALF)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sh_start),
        .word  (cur_word),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .busy  (sh_busy),
        .done  (sh_done)
    );

    seg_dwell_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SC_LOAD;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_d  = state_q;
        pos_d    = pos_q;
        sh_start = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        pos_en_n = '1;
        unique case (state_q)
            SC_LOAD: begin
                sh_start = 1'b1;
                state_d  = SC_SHIFT;
            end
            SC_SHIFT: begin
                if (sh_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(SETTLE_CYCLES - 1);
                    state_d  = SC_SETTLE;
                end
            end
            SC_SETTLE: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(DWELL_CYCLES - 1);
                    state_d  = SC_DWELL;
                end
            end
            SC_DWELL: begin
                pos_en_n[pos_q] = 1'b0;
                if (tmr_expired) begin
                    state_d = SC_LOAD;
                    pos_d   = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
                end
            end
            default: state_d = SC_LOAD;
        endcase
    end

    p_single_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pos_en_n));
    p_dark_while_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy |-> (&pos_en_n));
    p_scan_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_LOAD && $past(state_q) == SC_DWELL) |->
        (pos_q == (($past(pos_q) == LAST_POS) ? '0 : $past(pos_q) + 1'b1)));
    p_dark_after_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done |=> (&pos_en_n));
endmodule

// File: tb/seg_scan_tb.sv
module seg_scan_tb;
    localparam int H     = 2;
    localparam int S     = 4;
    localparam int D     = 64;
    localparam int SHIFT = 16 * H;
    localparam int SLOT  = 1 + SHIFT + S + D;
    localparam int FRAME = 5 * SLOT;
    localparam int NCYC  = 7 * FRAME;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] digit_val = '0;
    logic [3:0]  digit_blank = '0;
    logic [3:0]  digit_dp = '0;
    logic        dot_on = 1'b0;
    logic        spi_sclk, spi_mosi;
    logic [4:0]  pos_en_n;

    int errors = 0;
    int checks = 0;
    string cur_req = "R7";

    always #2 clk = ~clk;

    seg_scan #(.SCLK_HALF(H), .SETTLE_CYCLES(S), .DWELL_CYCLES(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .digit_val(digit_val), .digit_blank(digit_blank),
        .digit_dp(digit_dp), .dot_on(dot_on), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .pos_en_n(pos_en_n)
    );

    function automatic logic [6:0] seg_of(input logic [3:0] v);
        logic [6:0] t [16] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,
                               7'h7F,7'h6F,7'h77,7'h7C,7'h39,7'h5E,7'h79,7'h71};
        return t[v];
    endfunction

    function automatic logic [7:0] exp_word(input int p);
        if (p == 4) return dot_on ? 8'h7F : 8'hFF;
        if (digit_blank[p]) return 8'hFF;
        return {~digit_dp[p], ~seg_of(digit_val[4*p +: 4])};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic apply_stim(input int cyc);
        case (cyc)
            0:               begin digit_val = 16'h3210; digit_blank = 4'b0000; digit_dp = 4'b0000; dot_on = 1'b1; cur_req = "R7 R10"; end
            FRAME:           begin digit_val = 16'h7654; digit_dp = 4'b1010; dot_on = 1'b0; cur_req = "R9 R10"; end
            2*FRAME:         begin digit_val = 16'hBA98; digit_blank = 4'b0100; digit_dp = 4'b0000; cur_req = "R8"; end
            3*FRAME:         begin digit_val = 16'hFEDC; digit_blank = 4'b0000; dot_on = 1'b1; cur_req = "R7"; end
            4*FRAME + 50:    begin digit_val = 16'h5A5A; digit_dp = 4'b0001; cur_req = "R12"; end
            5*FRAME + 150:   begin digit_blank = 4'b1111; digit_dp = 4'b1111; cur_req = "R8 R12"; end
            default: ;
        endcase
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] word;
        int off, pos;
        logic [4:0] en_exp;
        logic sclk_exp, mosi_exp;
        word = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: values held during reset
        chk("R1", "en in reset", pos_en_n, 5'h1F);
        chk("R1", "sclk in reset", spi_sclk, 0);
        chk("R1", "mosi in reset", spi_mosi, 0);
        rst_n = 1'b1;
        off = 0;
        pos = 0;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            apply_stim(cyc);
            en_exp = 5'h1F;
            sclk_exp = 1'b0;
            mosi_exp = 1'b0;
            if (off == 0) begin
                word = exp_word(pos);
            end else if (off <= SHIFT) begin
                sclk_exp = ((off - 1) % (2 * H)) >= H;
                mosi_exp = word[7 - (off - 1) / (2 * H)];
            end else if (off > SHIFT + S) begin
                en_exp[pos] = 1'b0;
            end
            if (cyc == 0) chk("R1", "first cycle en", pos_en_n, 5'h1F);
            chk("R3", "enables low count", $countones(~pos_en_n) <= 1, 1);
            if (off <= SHIFT + S)
                chk("R4 R11", "enables dark in shift/settle", pos_en_n, en_exp);
            else
                chk({"R2 R11 ", cur_req}, "enable in dwell", pos_en_n, en_exp);
            chk("R5", "sclk", spi_sclk, sclk_exp);
            chk({"R6 ", cur_req}, "mosi", spi_mosi, mosi_exp);
            @(negedge clk);
            off++;
            if (off == SLOT) begin
                off = 0;
                pos = (pos + 1) % 5;
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule